// File: doc/BRIEF.md
# Lane Drive Request Adjuster

This block sits in the link-training path of a serial display transmitter. After each training step the sink reports, for every lane, the voltage swing and pre-emphasis it would like the source to use, and separately a post-cursor2 level. The adjuster takes those raw requests, limits them to what the source may legally drive, and produces two things: the per-lane control bytes and packed post-cursor2 bytes that the training firmware writes back to the sink, and the bare two-bit swing, pre-emphasis and post-cursor levels that go to the transmitter's analog drive.

Swing and pre-emphasis are limited as a pair, so that their sum never exceeds 3. A request that hits a limit comes back with a "maximum reached" flag set in the control byte. Lanes at or above the configured lane count are silenced.

A one-cycle `start` pulse samples the request inputs. All outputs are registered and change on the clock edge that samples `start`. `done` pulses high for the cycle that follows that edge. Between starts, every output holds its value.

Top module: `lane_drive_adjust`

## Requirements
- R1: The request for lane i is the 4-bit field of `req_status` beginning at bit 8*(i>>1) + 4*(i&1). Even lanes use the low nibble of a status byte and odd lanes use the high nibble. Within the field, bits 1:0 are the requested swing and bits 3:2 are the requested pre-emphasis.
- R2: An active lane whose requested pre-emphasis is 3 gets control byte 0x3C. This byte holds pre-emphasis 3 in bits 4:3, the pre-emphasis max flag in bit 5, swing 0 in bits 1:0 and the swing max flag in bit 2. The requested swing is ignored.
- R3: An active lane with pre-emphasis p < 3 and requested swing s >= 3-p gets swing 3-p with the swing max flag (bit 2) set, and pre-emphasis p with bit 5 clear.
- R4: An active lane with pre-emphasis p < 3 and swing s < 3-p gets control byte p*8 + s, with no flag set.
- R5: The post-cursor2 request of lane i is `pc_status` bits 2i+1:2i. A request of 3 becomes 3 with a flag in bit 2 (value 7); smaller requests pass through unchanged. The result for lane i is placed at bit 4*(i&1) of `pc_ctrl` byte i>>1. Each start rebuilds these bytes from zero, so no bits carry over from an earlier start.
- R6: A lane whose index is at or above `lane_count` produces a zero control byte, a zero post-cursor2 nibble and zero transmitter levels.
- R7: Outputs change only on the clock edge that samples `start` high. `done` is high for exactly the cycle after each such edge, and is low otherwise.
- R8: The transmitter outputs `tx_swing`, `tx_pree` and `tx_post` carry, for lane i at bits 2i+1:2i, the low two bits of that lane's clamped swing, pre-emphasis and post-cursor2.
- R9: While reset is asserted, every output is zero.
- R10: For every lane, the transmitter swing plus pre-emphasis never exceeds 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Sample the requests and update all outputs |
| req_status | input | 8*((LANES+1)/2) | Packed per-lane swing/pre-emphasis requests |
| pc_status | input | 2*LANES | Packed per-lane post-cursor2 requests |
| lane_count | input | $clog2(LANES+1) | Number of active lanes |
| lane_ctrl | output | 8*LANES | Per-lane clamped control bytes, lane i at byte i |
| pc_ctrl | output | 8*((LANES+1)/2) | Packed clamped post-cursor2 bytes |
| tx_swing | output | 2*LANES | Transmitter swing level per lane |
| tx_pree | output | 2*LANES | Transmitter pre-emphasis level per lane |
| tx_post | output | 2*LANES | Transmitter post-cursor2 level per lane |
| done | output | 1 | One-cycle pulse after a start |

## Verification
The bench builds the block with its default of four lanes. At this width both status bytes and both packed post-cursor2 bytes are in use, so every nibble position, and the odd-lane high-nibble path, is exercised. The stimulus sweeps every value of the 16-bit request word, which puts every swing/pre-emphasis pair on every lane. It pairs each sweep value with a changing post-cursor2 byte and with lane counts from 0 to 4. Starts are skipped at irregular intervals to show that the outputs hold.

// File: rtl/lda_pkg.sv
package lda_pkg;

  localparam logic [1:0] LVL_MAX = 2'd3;

  typedef struct packed {
    logic [2:0] pree;   // bit 2 = max flag
    logic [2:0] swing;  // bit 2 = max flag
  } drive_t;

  function automatic drive_t clamp_drive(input logic [3:0] nib);
    drive_t     r;
    logic [1:0] sw;
    logic [1:0] pe;
    logic [1:0] sw_lim;
    sw     = nib[1:0];
    pe     = nib[3:2];
    sw_lim = LVL_MAX - pe;
    if (pe >= LVL_MAX) begin
      r.pree  = {1'b1, LVL_MAX};
      r.swing = {1'b1, 2'd0};
    end else if (sw >= sw_lim) begin
      r.pree  = {1'b0, pe};
      r.swing = {1'b1, sw_lim};
    end else begin
      r.pree  = {1'b0, pe};
      r.swing = {1'b0, sw};
    end
    return r;
  endfunction

  function automatic logic [2:0] clamp_post(input logic [1:0] req);
    return (req >= LVL_MAX) ? {1'b1, LVL_MAX} : {1'b0, req};
  endfunction

  // pre-emphasis field at bits 5:3, swing field at bits 2:0
  function automatic logic [7:0] ctrl_byte(input drive_t d);
    return {2'b00, d.pree, d.swing};
  endfunction

endpackage

// File: rtl/lda_lane_clamp.sv
module lda_lane_clamp
  import lda_pkg::*;
(
  input  logic       active,
  input  logic [3:0] req_nib,
  input  logic [1:0] pc_req,
  output logic [7:0] ctrl_out,
  output logic [3:0] pc_nib,
  output logic [1:0] tx_sw,
  output logic [1:0] tx_pe,
  output logic [1:0] tx_pc
);

  drive_t     drv;
  logic [2:0] post;

  always_comb begin
    drv  = clamp_drive(req_nib);
    post = clamp_post(pc_req);
    if (active) begin
      ctrl_out = ctrl_byte(drv);
      pc_nib   = {1'b0, post};
      tx_sw    = drv.swing[1:0];
      tx_pe    = drv.pree[1:0];
      tx_pc    = post[1:0];
    end else begin
      ctrl_out = '0;
      pc_nib   = '0;
      tx_sw    = '0;
      tx_pe    = '0;
      tx_pc    = '0;
    end
  end

endmodule

// File: rtl/lda_pc_pack.sv
module lda_pc_pack #(
  parameter int LANES = 4,
  localparam int PC_BYTES = (LANES + 1) / 2
) (
  input  logic [4*LANES-1:0]    nibs,
  output logic [8*PC_BYTES-1:0] packed_out
);

  for (genvar b = 0; b < PC_BYTES; b++) begin : g_byte
    assign packed_out[8*b +: 4] = nibs[4*(2*b) +: 4];
    if (2*b + 1 < LANES) begin : g_hi
      assign packed_out[8*b+4 +: 4] = nibs[4*(2*b+1) +: 4];
    end else begin : g_pad
      assign packed_out[8*b+4 +: 4] = 4'h0;
    end
  end

endmodule

// File: rtl/lda_out_reg.sv
module lda_out_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         done
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q    <= '0;
      done <= 1'b0;
    end else begin
      done <= load;
      if (load) q <= d;
    end
  end

endmodule

// File: rtl/lane_drive_adjust.sv
module lane_drive_adjust #(
  parameter int LANES = 4,
  localparam int ST_BYTES = (LANES + 1) / 2,
  localparam int CNT_W    = $clog2(LANES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [8*ST_BYTES-1:0] req_status,
  input  logic [2*LANES-1:0]    pc_status,
  input  logic [CNT_W-1:0]      lane_count,
  output logic [8*LANES-1:0]    lane_ctrl,
  output logic [8*ST_BYTES-1:0] pc_ctrl,
  output logic [2*LANES-1:0]    tx_swing,
  output logic [2*LANES-1:0]    tx_pree,
  output logic [2*LANES-1:0]    tx_post,
  output logic                  done
);

  localparam int REG_W = 8*LANES + 8*ST_BYTES + 6*LANES;

  logic [8*LANES-1:0]    ctrl_c;
  logic [4*LANES-1:0]    pc_nib_c;
  logic [8*ST_BYTES-1:0] pc_c;
  logic [2*LANES-1:0]    sw_c, pe_c, po_c;
  logic [LANES-1:0]      lane_active;
  logic [REG_W-1:0]      reg_d, reg_q;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_active[i] = (lane_count > CNT_W'(i));
    lda_lane_clamp u_clamp (
      .active   (lane_active[i]),
      .req_nib  (req_status[8*(i>>1) + 4*(i&1) +: 4]),
      .pc_req   (pc_status[2*i +: 2]),
      .ctrl_out (ctrl_c[8*i +: 8]),
      .pc_nib   (pc_nib_c[4*i +: 4]),
      .tx_sw    (sw_c[2*i +: 2]),
      .tx_pe    (pe_c[2*i +: 2]),
      .tx_pc    (po_c[2*i +: 2])
    );
  end

  lda_pc_pack #(.LANES(LANES)) u_pack (
    .nibs       (pc_nib_c),
    .packed_out (pc_c)
  );

  assign reg_d = {po_c, pe_c, sw_c, pc_c, ctrl_c};

  lda_out_reg #(.W(REG_W)) u_oreg (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start),
    .d     (reg_d),
    .q     (reg_q),
    .done  (done)
  );

  assign {tx_post, tx_pree, tx_swing, pc_ctrl, lane_ctrl} = reg_q;

endmodule

// File: rtl/lda_checker.sv
module lda_checker #(
  parameter int LANES = 4,
  localparam int ST_BYTES = (LANES + 1) / 2,
  localparam int CNT_W    = $clog2(LANES + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [CNT_W-1:0]      lane_count,
  input logic [8*LANES-1:0]    lane_ctrl,
  input logic [8*ST_BYTES-1:0] pc_ctrl,
  input logic [2*LANES-1:0]    tx_swing,
  input logic [2*LANES-1:0]    tx_pree,
  input logic [2*LANES-1:0]    tx_post,
  input logic                  done
);

  AST_DONE_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> done); // R7

  AST_DONE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start)); // R7

  AST_HOLD_WITHOUT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> ($stable(lane_ctrl) && $stable(pc_ctrl) && $stable(tx_swing))); // R7

  for (genvar i = 0; i < LANES; i++) begin : g_chk
    localparam logic [CNT_W-1:0] IDX = CNT_W'(i);
    logic [7:0] cb;
    logic [3:0] pn;
    assign cb = lane_ctrl[8*i +: 8];
    assign pn = pc_ctrl[8*(i>>1) + 4*(i&1) +: 4];

    AST_SUM_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      ({1'b0, tx_swing[2*i +: 2]} + {1'b0, tx_pree[2*i +: 2]}) <= 3'd3); // R10

    AST_INACTIVE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (start && lane_count <= IDX) |=> (cb == 8'h00 && pn == 4'h0)); // R6

    AST_PRE_FLAG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      cb[5] |-> (cb == 8'h3C)); // R2

    AST_SWING_FLAG_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      cb[2] |-> (({1'b0, cb[1:0]} + {1'b0, cb[4:3]}) == 3'd3)); // R3

    AST_TX_FROM_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_swing[2*i +: 2] == cb[1:0] && tx_pree[2*i +: 2] == cb[4:3]
       && tx_post[2*i +: 2] == pn[1:0])); // R8

    AST_POST_FLAG_FORM: assert property (@(posedge clk) disable iff (!rst_n)
      pn[2] |-> (pn == 4'h7)); // R5
  end

endmodule

bind lane_drive_adjust lda_checker #(.LANES(LANES)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .lane_count (lane_count),
  .lane_ctrl  (lane_ctrl),
  .pc_ctrl    (pc_ctrl),
  .tx_swing   (tx_swing),
  .tx_pree    (tx_pree),
  .tx_post    (tx_post),
  .done       (done)
);

// File: tb/lane_drive_adjust_tb.sv
module lane_drive_adjust_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [15:0] req_status;
  logic [7:0]  pc_status;
  logic [2:0]  lane_count;
  logic [31:0] lane_ctrl;
  logic [15:0] pc_ctrl;
  logic [7:0]  tx_swing, tx_pree, tx_post;
  logic        done;

  int n_cmp = 0;
  int n_bad = 0;

  int    e_ctrl [4];
  int    e_pc   [2];
  int    e_sw   [4];
  int    e_pe   [4];
  int    e_po   [4];
  string e_tag  [4];
  int    e_done;

  always #5 clk = ~clk;

  lane_drive_adjust u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .req_status(req_status),
    .pc_status(pc_status), .lane_count(lane_count), .lane_ctrl(lane_ctrl),
    .pc_ctrl(pc_ctrl), .tx_swing(tx_swing), .tx_pree(tx_pree),
    .tx_post(tx_post), .done(done)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 4; i++) begin
      e_ctrl[i] = 0; e_sw[i] = 0; e_pe[i] = 0; e_po[i] = 0; e_tag[i] = "R9";
    end
    e_pc[0] = 0; e_pc[1] = 0; e_done = 0;
  endtask

  // behavioural model of one start
  task automatic model_load(input int rq, input int pc, input int cnt);
    e_pc[0] = 0; e_pc[1] = 0;
    for (int i = 0; i < 4; i++) begin
      int nib, sw, pe, lim, s, pr, pn;
      nib = (rq >> (4*i)) % 16;
      sw  = nib % 4;
      pe  = nib / 4;
      pr  = (pc >> (2*i)) % 4;
      if (i >= cnt) begin
        e_ctrl[i] = 0; pn = 0; e_tag[i] = "R6";
      end else begin
        if (pe == 3) begin
          e_ctrl[i] = 'h3C; e_tag[i] = "R2";
        end else begin
          lim = 3 - pe;
          if (sw >= lim) begin s = lim + 4; e_tag[i] = "R3"; end
          else           begin s = sw;      e_tag[i] = "R4"; end
          e_ctrl[i] = pe*8 + s;
        end
        pn = (pr == 3) ? 7 : pr;
      end
      e_sw[i] = e_ctrl[i] % 4;
      e_pe[i] = (e_ctrl[i] / 8) % 4;
      e_po[i] = pn % 4;
      e_pc[i/2] = e_pc[i/2] + pn * ((i % 2 == 1) ? 16 : 1);
    end
  endtask

  task automatic compare_all();
    check("R7 done", int'(done), e_done);
    for (int i = 0; i < 4; i++) begin
      check({e_tag[i], " ctrl byte"}, int'(lane_ctrl[8*i +: 8]), e_ctrl[i]);
      check("R8 tx swing", int'(tx_swing[2*i +: 2]), e_sw[i]);
      check("R8 tx pre-emphasis", int'(tx_pree[2*i +: 2]), e_pe[i]);
      check("R8 tx post", int'(tx_post[2*i +: 2]), e_po[i]);
      check("R10 sum<=3", int'((tx_swing[2*i +: 2] + tx_pree[2*i +: 2]) > 3), 0);
    end
    check("R5 pc byte0", int'(pc_ctrl[7:0]), e_pc[0]);
    check("R5 pc byte1", int'(pc_ctrl[15:8]), e_pc[1]);
  endtask

  // called at a negedge; drives, waits for the edge, then compares at the next negedge
  task automatic step(input logic st, input int rq, input int pc, input int cnt);
    start      = st;
    req_status = 16'(rq);
    pc_status  = 8'(pc);
    lane_count = 3'(cnt);
    @(posedge clk);
    if (st) model_load(rq, pc, cnt);
    e_done = st ? 1 : 0;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_bad++;
    $display("FAIL R7 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; req_status = '1; pc_status = '1; lane_count = 3'd4;
    model_clear();
    repeat (3) @(negedge clk);
    compare_all();                         // R9 reset state
    rst_n = 1'b1;

    // R1: only lane 1 (high nibble of byte 0) requests swing 1
    step(1'b1, 'h0010, 0, 4);
    check("R1 odd lane high nibble", int'(lane_ctrl[15:8]), 1);
    check("R1 even lane untouched", int'(lane_ctrl[7:0]), 0);
    // R2: max pre-emphasis on all lanes, swing requests ignored
    step(1'b1, 'hFCDE, 'hFF, 4);
    // R5 stale: post-cursor cleared on next start
    step(1'b1, 'h0000, 'h00, 4);
    check("R5 no stale post bits", int'(pc_ctrl), 0);
    // R3 / R4 mixes
    step(1'b1, 'h3210, 'hE4, 4);
    step(1'b1, 'h9876, 'h1B, 3);
    // R6 lane count 0 and 1
    step(1'b1, 'h5555, 'hFF, 0);
    step(1'b1, 'hAAAA, 'hFF, 1);
    // R7 hold while inputs move without start
    step(1'b0, 'h1234, 'h56, 4);
    step(1'b0, 'hFFFF, 'hFF, 2);

    for (int v = 0; v < 65536; v++)
      step(((v % 7) != 3), v, (v ^ (v >> 8)) % 256, v % 5);

    rst_n = 1'b0;
    @(posedge clk);
    model_clear();
    @(negedge clk);
    compare_all();                         // R9 reset after activity
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule